// File: doc/BRIEF.md
# Audio Clock Ratio Mode Detector

The block runs on the master audio clock and watches the left/right frame clock. It measures how many master-clock cycles fall between two rising frame edges and maps that count onto one of two rate modes: base rate or high rate. An oversampling converter path downstream uses the chosen mode to pace three single-cycle strobes. The first strobe starts a new 4x interpolated sample. The second marks a repeat of the sample being held. The third marks a 1-bit modulator output slot.

Only a measurement that is seen on two frames in a row can change the mode, so one bad frame edge cannot flip it. A frame length that matches none of the supported ratios raises a flag and stops the strobes, but the last good mode stays in place. Base rate gives 128 modulator slots per frame. High rate gives 64 slots per frame and is meant for frame rates up to 100 kHz.

Top module: `audio_ratio_detector`

## Requirements
- R1: A measured ratio of 256, 384 or 512 master cycles per frame, once confirmed, sets `mode_known`=1 and `mode_fast`=0.
- R2: A measured ratio of 128 or 192, once confirmed, sets `mode_known`=1 and `mode_fast`=1.
- R3: While running, `stb_mod` pulses 128 times per frame in base rate and 64 times in high rate. The pulses are evenly spaced at ratio/128 or ratio/64 cycles.
- R4: `stb_interp` pulses 4 times per frame. It rides on the first `stb_mod` after each frame edge and on every 32nd (base) or 16th (high) one after that.
- R5: `stb_hold` pulses on every `stb_mod` that carries no `stb_interp`. That gives 124 per frame in base rate and 60 in high rate. It never pulses together with `stb_interp`.
- R6: The mode changes only after the same ratio is measured on two consecutive frames. A single odd frame leaves the mode unchanged.
- R7: An unsupported ratio sets `ratio_bad`=1, keeps all strobes at 0 and keeps the last confirmed mode. Two matching good frames clear the flag.
- R8: After reset, `mode_known`, `mode_fast`, `ratio_bad` and all strobes are 0.
- R9: Each frame's first `stb_mod`/`stb_interp` appears on the third master-clock edge after the frame clock rises. Two of those edges come from synchronizer stages and one from the strobe register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master audio clock |
| rst_n | input | 1 | Active-low reset, synchronous to mclk |
| lrck_in | input | 1 | Frame clock, asynchronous to mclk |
| mode_known | output | 1 | A mode has been confirmed |
| mode_fast | output | 1 | 1 = high-rate mode, 0 = base-rate mode |
| ratio_bad | output | 1 | Last measured ratio is unsupported |
| stb_interp | output | 1 | Interpolated-sample start strobe |
| stb_hold | output | 1 | Held-sample repeat strobe |
| stb_mod | output | 1 | Modulator output slot strobe |

## Verification
The bench builds the block with its default parameters. These are a 10-bit period counter, 128 and 64 modulator slots per frame, and an interpolation factor of 4. The counter range lets the bench push an 1000-cycle frame and still get an honest "unsupported" result. It also lets the bench drive every supported ratio at its exact length, so slot counts and the even spacing can be checked over a whole steady-state frame. Directed sequences then cover the single odd frame, a real switch between modes, and recovery from a bad stretch.

// File: rtl/ard_pkg.sv
package ard_pkg;
  typedef enum logic [2:0] {
    RK_NONE = 3'd0,
    RK_128  = 3'd1,
    RK_192  = 3'd2,
    RK_256  = 3'd3,
    RK_384  = 3'd4,
    RK_512  = 3'd5
  } ratio_kind_e;

  function automatic ratio_kind_e classify(input int cycles);
    case (cycles)
      128:     return RK_128;
      192:     return RK_192;
      256:     return RK_256;
      384:     return RK_384;
      512:     return RK_512;
      default: return RK_NONE;
    endcase
  endfunction

  function automatic int ratio_of(input ratio_kind_e k);
    case (k)
      RK_128:  return 128;
      RK_192:  return 192;
      RK_256:  return 256;
      RK_384:  return 384;
      RK_512:  return 512;
      default: return 0;
    endcase
  endfunction

  function automatic logic is_fast(input ratio_kind_e k);
    return (k == RK_128) || (k == RK_192);
  endfunction
endpackage

// File: rtl/ard_edge_sync.sv
module ard_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [2:0] sh;
  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[1:0], async_in};
  end
  assign rise = sh[1] & ~sh[2];
endmodule

// File: rtl/ard_period_meter.sv
module ard_period_meter
  import ard_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rise,
  output logic        meas,
  output ratio_kind_e meas_kind
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt;
  logic             seen;
  logic [CNT_W:0]   period;

  assign period    = {1'b0, cnt} + 1'b1;
  assign meas      = rise && seen;
  assign meas_kind = classify(int'(period));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      seen <= 1'b0;
    end else if (rise) begin
      cnt  <= '0;
      seen <= 1'b1;
    end else if (cnt != CNT_MAX) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ard_mode_filter.sv
module ard_mode_filter
  import ard_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        meas,
  input  ratio_kind_e meas_kind,
  output ratio_kind_e kind_q,
  output logic        bad_q,
  output ratio_kind_e kind_nx,
  output logic        run_nx
);
  ratio_kind_e last_q, last_nx;
  logic        run_q, bad_nx;

  always_comb begin
    kind_nx = kind_q;
    bad_nx  = bad_q;
    run_nx  = run_q;
    last_nx = last_q;
    if (meas) begin
      last_nx = meas_kind;
      if (meas_kind == RK_NONE) begin
        bad_nx = 1'b1;
        run_nx = 1'b0;
      end else if (meas_kind == last_q) begin
        kind_nx = meas_kind;
        bad_nx  = 1'b0;
        run_nx  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q <= RK_NONE;
      last_q <= RK_NONE;
      bad_q  <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      kind_q <= kind_nx;
      last_q <= last_nx;
      bad_q  <= bad_nx;
      run_q  <= run_nx;
    end
  end
endmodule

// File: rtl/ard_strobe_gen.sv
module ard_strobe_gen
  import ard_pkg::*;
#(
  parameter int CNT_W     = 10,
  parameter int MOD_BASE  = 128,
  parameter int MOD_FAST  = 64,
  parameter int INTERP    = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_start,
  input  logic        run_nx,
  input  ratio_kind_e kind_nx,
  output logic        stb_interp,
  output logic        stb_hold,
  output logic        stb_mod
);
  localparam int IDX_W = $clog2(MOD_BASE) + 1;
  localparam logic [IDX_W-1:0] N_BASE  = IDX_W'(MOD_BASE);
  localparam logic [IDX_W-1:0] N_FAST  = IDX_W'(MOD_FAST);
  localparam logic [IDX_W-1:0] GM_BASE = IDX_W'(MOD_BASE / INTERP - 1);
  localparam logic [IDX_W-1:0] GM_FAST = IDX_W'(MOD_FAST / INTERP - 1);

  logic             run_r, fast_r;
  logic [CNT_W:0]   ratio_r, acc, sum;
  logic [IDX_W-1:0] idx, n_cur, grp_m1;

  assign n_cur  = fast_r ? N_FAST : N_BASE;
  assign grp_m1 = fast_r ? GM_FAST : GM_BASE;
  assign sum    = acc + (CNT_W+1)'(n_cur);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_r <= 1'b0; fast_r <= 1'b0; ratio_r <= '0; acc <= '0; idx <= '0;
      stb_mod <= 1'b0; stb_interp <= 1'b0; stb_hold <= 1'b0;
    end else begin
      stb_mod <= 1'b0; stb_interp <= 1'b0; stb_hold <= 1'b0;
      if (frame_start) begin
        run_r   <= run_nx;
        fast_r  <= is_fast(kind_nx);
        ratio_r <= (CNT_W+1)'(ratio_of(kind_nx));
        acc     <= '0;
        if (run_nx) begin
          stb_mod    <= 1'b1;
          stb_interp <= 1'b1;
          idx        <= IDX_W'(1);
        end else begin
          idx <= '0;
        end
      end else if (run_r && idx < n_cur) begin
        if (sum >= ratio_r) begin
          acc     <= sum - ratio_r;
          stb_mod <= 1'b1;
          if ((idx & grp_m1) == '0) stb_interp <= 1'b1;
          else                      stb_hold   <= 1'b1;
          idx <= idx + 1'b1;
        end else begin
          acc <= sum;
        end
      end
    end
  end
endmodule

// File: rtl/audio_ratio_detector.sv
module audio_ratio_detector
  import ard_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int MOD_BASE = 128,
  parameter int MOD_FAST = 64,
  parameter int INTERP   = 4
) (
  input  logic mclk,
  input  logic rst_n,
  input  logic lrck_in,
  output logic mode_known,
  output logic mode_fast,
  output logic ratio_bad,
  output logic stb_interp,
  output logic stb_hold,
  output logic stb_mod
);
  logic        rise, meas, run_nx;
  ratio_kind_e meas_kind, kind_q, kind_nx;

  ard_edge_sync u_sync (
    .clk(mclk), .rst_n(rst_n), .async_in(lrck_in), .rise(rise)
  );

  ard_period_meter #(.CNT_W(CNT_W)) u_meter (
    .clk(mclk), .rst_n(rst_n), .rise(rise), .meas(meas), .meas_kind(meas_kind)
  );

  ard_mode_filter u_filt (
    .clk(mclk), .rst_n(rst_n), .meas(meas), .meas_kind(meas_kind),
    .kind_q(kind_q), .bad_q(ratio_bad), .kind_nx(kind_nx), .run_nx(run_nx)
  );

  ard_strobe_gen #(
    .CNT_W(CNT_W), .MOD_BASE(MOD_BASE), .MOD_FAST(MOD_FAST), .INTERP(INTERP)
  ) u_gen (
    .clk(mclk), .rst_n(rst_n), .frame_start(rise), .run_nx(run_nx),
    .kind_nx(kind_nx), .stb_interp(stb_interp), .stb_hold(stb_hold),
    .stb_mod(stb_mod)
  );

  assign mode_known = (kind_q != RK_NONE);
  assign mode_fast  = is_fast(kind_q);
endmodule

// File: rtl/ard_checker.sv
module ard_checker (
  input logic mclk,
  input logic rst_n,
  input logic mode_known,
  input logic mode_fast,
  input logic ratio_bad,
  input logic stb_interp,
  input logic stb_hold,
  input logic stb_mod
);
  AST_FAST_NEEDS_KNOWN: assert property (@(posedge mclk) disable iff (!rst_n)
    mode_fast |-> mode_known); // R2
  AST_INTERP_ON_SLOT: assert property (@(posedge mclk) disable iff (!rst_n)
    stb_interp |-> stb_mod); // R4
  AST_HOLD_EXCLUSIVE: assert property (@(posedge mclk) disable iff (!rst_n)
    stb_hold |-> (stb_mod && !stb_interp)); // R5
  AST_SLOT_CLASSIFIED: assert property (@(posedge mclk) disable iff (!rst_n)
    stb_mod |-> (stb_interp || stb_hold)); // R5
  AST_BAD_SILENT: assert property (@(posedge mclk) disable iff (!rst_n)
    ratio_bad |-> !stb_mod); // R7
  AST_BAD_KEEPS_MODE: assert property (@(posedge mclk) disable iff (!rst_n)
    $rose(ratio_bad) |-> ($stable(mode_known) && $stable(mode_fast))); // R7
  AST_STROBE_NEEDS_MODE: assert property (@(posedge mclk) disable iff (!rst_n)
    stb_mod |-> mode_known); // R3
endmodule

bind audio_ratio_detector ard_checker u_chk (
  .mclk(mclk), .rst_n(rst_n), .mode_known(mode_known), .mode_fast(mode_fast),
  .ratio_bad(ratio_bad), .stb_interp(stb_interp), .stb_hold(stb_hold),
  .stb_mod(stb_mod)
);

// File: tb/sim_audio_ratio_detector.sv
`timescale 1ns/1ps
module sim_audio_ratio_detector;
  logic clk = 1'b0, rst_n = 1'b0, lrck = 1'b0;
  logic mode_known, mode_fast, ratio_bad, stb_interp, stb_hold, stb_mod;
  int n_chk = 0, n_bad = 0;
  int c_mod, c_int, c_hold, g_min, g_max, al_int, al_mod;
  logic done = 1'b0;

  always #4 clk = ~clk;

  audio_ratio_detector u0 (
    .mclk(clk), .rst_n(rst_n), .lrck_in(lrck), .mode_known(mode_known),
    .mode_fast(mode_fast), .ratio_bad(ratio_bad), .stb_interp(stb_interp),
    .stb_hold(stb_hold), .stb_mod(stb_mod)
  );

  // ratio, known, fast, bad, slots per frame
  localparam int NV = 7;
  localparam int VEC [NV][5] = '{
    '{256, 1, 0, 0, 128}, '{384, 1, 0, 0, 128}, '{512, 1, 0, 0, 128},
    '{128, 1, 1, 0, 64},  '{192, 1, 1, 0, 64},  '{300, 0, 0, 1, 0},
    '{1000, 0, 0, 1, 0}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One frame clock period of p cycles; counts strobes seen in it.
  task automatic frame(input int p);
    int last;
    last = -1;
    c_mod = 0; c_int = 0; c_hold = 0; g_min = 1 << 20; g_max = 0;
    al_int = 0; al_mod = 0;
    for (int i = 0; i < p; i++) begin
      @(negedge clk);
      if (stb_mod) begin
        c_mod++;
        if (last >= 0) begin
          if (i - last < g_min) g_min = i - last;
          if (i - last > g_max) g_max = i - last;
        end
        last = i;
      end
      if (stb_interp) c_int++;
      if (stb_hold) c_hold++;
      if (i == 3) begin al_int = int'(stb_interp); al_mod = int'(stb_mod); end
      lrck = (i < p / 2);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; lrck = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk("R8 mode_known", int'(mode_known), 0);
    chk("R8 mode_fast", int'(mode_fast), 0);
    chk("R8 ratio_bad", int'(ratio_bad), 0);
    chk("R8 strobes", int'(stb_mod | stb_hold | stb_interp), 0);

    for (int v = 0; v < NV; v++) begin
      int p, n;
      p = VEC[v][0]; n = VEC[v][4];
      do_reset();
      for (int f = 0; f < 5; f++) frame(p);
      chk(VEC[v][2] ? "R2 mode_known" : "R1 mode_known", int'(mode_known), VEC[v][1]);
      chk(VEC[v][2] ? "R2 mode_fast" : "R1 mode_fast", int'(mode_fast), VEC[v][2]);
      chk("R7 ratio_bad", int'(ratio_bad), VEC[v][3]);
      chk("R3 slot count", c_mod, n);
      chk("R4 interp count", c_int, n == 0 ? 0 : 4);
      chk("R5 hold count", c_hold, n == 0 ? 0 : n - 4);
      if (n != 0) begin
        chk("R3 min spacing", g_min, p / n);
        chk("R3 max spacing", g_max, p / n);
        chk("R9 interp at edge+3", al_int, 1);
        chk("R9 slot at edge+3", al_mod, 1);
      end
    end

    // R6: one odd frame does not move the mode
    do_reset();
    repeat (4) frame(256);
    frame(128);
    frame(256);
    chk("R6 glitch mode_fast", int'(mode_fast), 0);
    chk("R6 glitch mode_known", int'(mode_known), 1);
    frame(256);
    chk("R6 glitch slots kept", c_mod, 128);

    // R6: real switch needs two equal measurements
    do_reset();
    repeat (4) frame(256);
    frame(128);
    frame(128);
    chk("R6 after one fast measure", int'(mode_fast), 0);
    frame(128);
    chk("R6 after two fast measures", int'(mode_fast), 1);
    frame(128);
    chk("R6 fast slots", c_mod, 64);

    // R7: unsupported keeps last mode, then recovers
    do_reset();
    repeat (4) frame(192);
    repeat (3) frame(300);
    chk("R7 bad flag", int'(ratio_bad), 1);
    chk("R7 mode kept known", int'(mode_known), 1);
    chk("R7 mode kept fast", int'(mode_fast), 1);
    chk("R7 strobes off", c_mod + c_int + c_hold, 0);
    repeat (3) frame(512);
    chk("R7 recovered flag", int'(ratio_bad), 0);
    chk("R1 recovered base", int'(mode_fast), 0);
    frame(512);
    chk("R3 recovered slots", c_mod, 128);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule